// File: doc/BRIEF.md
# Backplane Window Mapping Controller

This block places the 4 KB register region of one chosen core into a host-visible aperture. It does this by programming a 32-bit window register that sits behind a simple register-bus master port. A start pulse carries a core index. The controller forms the backplane address as a fixed base plus the index times 4 KB, writes that address into the window register, and then reads the register back.

A write is not guaranteed to stick. When the readback differs from the intended value, the controller writes and reads again. It stops after a bounded number of attempts and then signals either success or failure. The last value read back stays on an output. That value is also decoded into a core index, and the controller flags a readback that cannot be a valid mapping.

Top module: `win_map_ctrl`

## Requirements
- R1: Each write carries bus_addr = 0x80 and bus_wdata = 0x18000000 + core_idx * 0x1000, where core_idx is the value sampled with the accepted start.
- R2: Each attempt is exactly one write (bus_we=1) followed by one read (bus_we=0). bus_req and bus_we stay steady until bus_ack is seen for that access.
- R3: When a readback equals the target, the controller pulses done for one cycle with ok=1 and err=0, and last_rb equals the target.
- R4: A mismatching readback starts a new attempt. After 10 attempts have all mismatched, done pulses with err=1 and ok=0.
- R5: last_rb holds the most recent readback from the end of the operation until the next read completes.
- R6: map_core equals bits [19:12] of (last_rb - 0x18000000).
- R7: map_bad is 1 when last_rb is below 0x18000000, when last_rb[11:0] is nonzero, or when the decoded index exceeds 8 bits. Otherwise map_bad is 0.
- R8: A start pulse that arrives while busy is ignored. It does not change the target, does not add accesses, and does not produce a second done.
- R9: After reset the controller is idle: busy, bus_req, done, ok and err are all 0, and last_rb is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a mapping operation |
| core_idx | input | IDX_W | Core to map |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Mapping confirmed |
| err | output | 1 | Retry limit exhausted |
| last_rb | output | 32 | Most recent readback |
| map_core | output | IDX_W | Core index decoded from last_rb |
| map_bad | output | 1 | last_rb is not a valid mapping |
| bus_req | output | 1 | Register-bus request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 8 | Register offset |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with ack |
| bus_ack | input | 1 | Access completed |

## Verification
Some rules hold on every cycle, and assertions check those. They cover request hold until ack, write-before-read ordering, ok and err being exclusive at done, the attempt cap, agreement between a successful readback and the target, and a target that stays fixed while busy. The retry count itself needs scenarios, so the bench supplies them. It uses a responder that drops a chosen number of writes or ignores all writes, and it counts the writes that result. Only such scenarios can show the decode of deliberately bad readbacks and the absence of a second done after a start pulse that is ignored.

// File: rtl/win_map_ctrl.sv
module win_map_ctrl #(
  parameter int          IDX_W      = 8,
  parameter int          SHIFT      = 12,
  parameter int          MAX_TRIES  = 10,
  parameter logic [31:0] BASE       = 32'h1800_0000,
  parameter logic [7:0]  WIN_OFFSET = 8'h80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] core_idx,
  output logic             busy,
  output logic             done,
  output logic             ok,
  output logic             err,
  output logic [31:0]      last_rb,
  output logic [IDX_W-1:0] map_core,
  output logic             map_bad,
  output logic             bus_req,
  output logic             bus_we,
  output logic [7:0]       bus_addr,
  output logic [31:0]      bus_wdata,
  input  logic [31:0]      bus_rdata,
  input  logic             bus_ack
);
  localparam int TW = $clog2(MAX_TRIES + 1);
  localparam int HI = SHIFT + IDX_W;

  typedef enum logic [1:0] {S_IDLE, S_WR, S_RD} st_t;
  st_t st;
  logic [31:0]   tgt;
  logic [TW-1:0] tries;
  logic [31:0]   off;

  assign busy      = (st != S_IDLE);
  assign bus_req   = busy;
  assign bus_we    = (st == S_WR);
  assign bus_addr  = WIN_OFFSET;
  assign bus_wdata = tgt;

  assign off      = last_rb - BASE;
  assign map_core = off[SHIFT +: IDX_W];
  assign map_bad  = (last_rb < BASE) || (|last_rb[SHIFT-1:0]) || (|off[31:HI]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; tgt <= '0; tries <= '0;
      done <= 1'b0; ok <= 1'b0; err <= 1'b0; last_rb <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          tgt   <= BASE + (32'(core_idx) << SHIFT);
          tries <= '0;
          ok    <= 1'b0;
          err   <= 1'b0;
          st    <= S_WR;
        end
        S_WR: if (bus_ack) st <= S_RD;
        S_RD: if (bus_ack) begin
          last_rb <= bus_rdata;
          tries   <= tries + 1'b1;
          if (bus_rdata == tgt) begin
            ok <= 1'b1; done <= 1'b1; st <= S_IDLE;
          end else if (tries == TW'(MAX_TRIES - 1)) begin
            err <= 1'b1; done <= 1'b1; st <= S_IDLE;
          end else st <= S_WR;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && (bus_we == $past(bus_we)));
  p_wr_then_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && bus_ack |=> bus_req && !bus_we);
  p_tgt_form_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bus_wdata >= BASE) && (bus_wdata[SHIFT-1:0] == '0));
  p_done_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ok ^ err) && !busy);
  p_ok_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done && ok |-> last_rb == bus_wdata);
  p_tries_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tries <= TW'(MAX_TRIES));
  p_err_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done && err |-> tries == TW'(MAX_TRIES));
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(bus_wdata));
endmodule

// File: tb/win_map_ctrl_bench.sv
module win_map_ctrl_bench;
  logic clk = 0, rst_n = 0, start = 0;
  logic [7:0] core_idx = 0;
  logic busy, done, ok, err, map_bad, bus_req, bus_we, bus_ack = 0;
  logic [31:0] last_rb, bus_wdata, bus_rdata;
  logic [7:0] map_core, bus_addr;

  always #4 clk = ~clk;

  win_map_ctrl u_win_map_ctrl (.clk, .rst_n, .start, .core_idx, .busy, .done, .ok,
    .err, .last_rb, .map_core, .map_bad, .bus_req, .bus_we, .bus_addr, .bus_wdata,
    .bus_rdata, .bus_ack);

  int tests = 0, fails = 0, wcount = 0, rcount = 0, drop_cnt = 0, bad_addr = 0, dones = 0;
  bit stuck = 0;
  logic [31:0] winreg = 0;
  assign bus_rdata = winreg;

  // responder
  always @(posedge clk) begin
    if (bus_req && !bus_ack) begin
      bus_ack <= 1;
      if (bus_addr != 8'h80) bad_addr++;
      if (bus_we) begin
        wcount++;
        if (stuck) ;
        else if (drop_cnt > 0) drop_cnt--;
        else winreg <= bus_wdata;
      end else rcount++;
    end else bus_ack <= 0;
  end

  logic [31:0] q_rb[$];
  logic [1:0]  q_st[$];
  int          q_n[$];

  task automatic chk(input string req, input logic [31:0] act, exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) if (rst_n && done) begin
    logic [31:0] rb, off;
    logic [1:0] s;
    int n;
    dones++;
    if (q_rb.size() == 0) chk("R8 unexpected done", 1, 0);
    else begin
      rb = q_rb.pop_front(); s = q_st.pop_front(); n = q_n.pop_front();
      off = rb - 32'h1800_0000;
      chk("R3/R4 ok,err", {30'd0, ok, err}, {30'd0, s});
      chk("R5 last_rb", last_rb, rb);
      chk("R2/R4 writes", wcount, n);
      chk("R2 reads", rcount, n);
      chk("R6 map_core", {24'd0, map_core}, {24'd0, off[19:12]});
      chk("R7 map_bad", {31'd0, map_bad},
          {31'd0, (rb < 32'h1800_0000) || (rb[11:0] != 0) || (off[31:20] != 0)});
    end
  end

  task automatic map_op(input logic [7:0] idx, input int drops, input bit stk,
                        input logic [31:0] pre, input bit poke);
    logic [31:0] tgt;
    bit fail;
    int d0;
    tgt = 32'h1800_0000 + {24'd0, idx} * 32'h1000;
    fail = stk || drops >= 10;
    @(negedge clk);
    winreg = pre; drop_cnt = drops; stuck = stk; wcount = 0; rcount = 0;
    q_rb.push_back(fail ? pre : tgt);
    q_st.push_back(fail ? 2'b01 : 2'b10);
    q_n.push_back(fail ? 10 : drops + 1);
    d0 = dones;
    core_idx = idx; start = 1;
    @(negedge clk); start = 0;
    chk("R1 wdata", bus_wdata, tgt);
    if (poke) begin
      repeat (3) @(negedge clk);
      core_idx = idx + 8'd4; start = 1;
      @(negedge clk); start = 0;
      chk("R8 target kept", bus_wdata, tgt);
    end
    wait (dones != d0);
    repeat (6) @(negedge clk);
    chk("R8 single done", dones, d0 + 1);
    chk("R5 held", last_rb, fail ? pre : tgt);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 busy", {31'd0, busy}, 0);
    chk("R9 bus_req", {31'd0, bus_req}, 0);
    chk("R9 flags", {29'd0, done, ok, err}, 0);
    chk("R9 last_rb", last_rb, 0);
    rst_n = 1;
    map_op(8'd0, 0, 0, 32'h0, 0);
    map_op(8'd5, 3, 0, 32'h0, 0);
    map_op(8'd255, 9, 0, 32'h0, 0);
    map_op(8'd7, 0, 1, 32'h1800_3000, 0);
    map_op(8'd7, 0, 1, 32'h1800_2010, 0);
    map_op(8'd1, 0, 1, 32'h0000_1000, 0);
    map_op(8'd1, 0, 1, 32'h1810_0000, 0);
    map_op(8'd2, 2, 0, 32'h0, 1);
    chk("R1/R2 bus_addr", bad_addr, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule